// File: doc/BRIEF.md
# Multiplexed bus address demultiplexer

This block sits between a processor whose pins carry address, data and status at different times, and a system that wants a steady address bus with byte-lane selects. On every clock edge at which the address-latch-enable strobe is high, it loads the 16 shared address/data lines and the 4 upper address/status lines as a 20-bit address. It also loads the high-byte enable, which shares its pin with a later status bit. The first edge at which the strobe is seen low again captures the two segment status bits now on the upper lines. From then until the strobe rises again, the address is marked valid and two bank selects are driven.

A small phase machine orders the work. It has three states. `ST_IDLE` is the state after reset, when no address has been taken. `ST_LATCH` follows an edge with the strobe high, while the address register follows the pins. `ST_VALID` follows the first strobe-low edge, while the address and status are held. The transitions are: *open* (IDLE or VALID to LATCH, strobe high), *close* (LATCH to VALID, strobe low, status captured), *stay* (LATCH to LATCH, or VALID to VALID). When hold acknowledge is high, the block releases the bus to another master. Its output-enable flag drops, and its address, segment, valid and select outputs read zero. The held state is not touched.

Top module: `addr_demux`

## Requirements
- R1: After reset `addr_o`, `seg_o`, `addr_vld_o`, `even_sel_o` and `odd_sel_o` are 0, and `oe_o` is 1 while `hlda_i` is low.
- R2: At each rising edge with `ale_i` high, `{as_i, ad_i}` is loaded, and `addr_o` shows that value from the edge on. Address bit 0 is `ad_i[0]` and bit 19 is `as_i[3]`.
- R3: At edges with `ale_i` low, `addr_o` keeps its value whatever `ad_i` and `as_i` carry.
- R4: At the first edge with `ale_i` low after an edge with it high, `seg_o` takes `as_i[1:0]` (S4 on bit 1, S3 on bit 0). It then holds through later changes of `as_i` until a new strobe pulse closes.
- R5: The segment code is passed unchanged: 00 extra, 01 stack, 10 code or none, 11 data.
- R6: `addr_vld_o` is 1 from the edge that closes a strobe pulse up to the next edge with `ale_i` high. It is 0 in `ST_IDLE` and `ST_LATCH`.
- R7: While the address is valid, `even_sel_o` is the inverse of latched A0, and `odd_sel_o` is the inverse of the latched active-low high-byte enable. For (enable, A0): 00 selects both banks, 01 selects only odd, 10 selects only even, and 11 selects none. Both selects are 0 when the address is not valid.
- R8: While `hlda_i` is 1, `oe_o` is 0 and `addr_o`, `seg_o`, `addr_vld_o`, `even_sel_o` and `odd_sel_o` read 0. When `hlda_i` falls, the held values reappear unchanged.
- R9: An edge with `ale_i` high while the address is valid reopens the latch, and `addr_vld_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_i | input | 16 | Shared address/data lines |
| as_i | input | 4 | Upper address bits 19..16, later status S6..S3 |
| ale_i | input | 1 | Address latch enable strobe |
| bhe_n_i | input | 1 | Active-low high-byte enable (address phase) |
| hlda_i | input | 1 | Hold acknowledge, bus released when 1 |
| addr_o | output | 20 | Latched system address |
| seg_o | output | 2 | Captured segment code |
| even_sel_o | output | 1 | Even (low byte) bank select |
| odd_sel_o | output | 1 | Odd (high byte) bank select |
| addr_vld_o | output | 1 | Latched address is valid |
| oe_o | output | 1 | Outputs driven (low during hold) |

## Verification
Address loading, segment capture and the valid flag are each due one register after the edge that samples the strobe. The bench therefore drives at falling edges and checks at the next falling edge, half a period after the sampling edge. The hold release acts without a register, so it is checked one nanosecond after `hlda_i` changes, with no clock edge in between. The held-value checks (R3, R4) are made one further edge after the capture, with different data on the pins.

// File: rtl/addr_demux_pkg.sv
package addr_demux_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_VALID = 2'd2
    } bus_phase_t;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_code_t;
endpackage

// File: rtl/phase_fsm.sv
module phase_fsm
    import addr_demux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ale_i,
    output bus_phase_t phase_o,
    output logic       load_o,
    output logic       capture_o,
    output logic       valid_o
);
    bus_phase_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ale_i ? ST_LATCH : ST_IDLE;
            ST_LATCH: state_d = ale_i ? ST_LATCH : ST_VALID;
            ST_VALID: state_d = ale_i ? ST_LATCH : ST_VALID;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        phase_o   = state_q;
        load_o    = ale_i;
        capture_o = (state_q == ST_LATCH) && !ale_i;
        valid_o   = (state_q == ST_VALID);
    end
endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
    parameter int AD_W = 16,
    parameter int AS_W = 4,
    localparam int ADDR_W = AD_W + AS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [AD_W-1:0]   ad_i,
    input  logic [AS_W-1:0]   as_i,
    input  logic              bhe_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bhe_n_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o  <= '0;
            bhe_n_o <= 1'b1;
        end else if (load_i) begin
            addr_o  <= {as_i, ad_i};
            bhe_n_o <= bhe_n_i;
        end
    end
endmodule

// File: rtl/stat_capture.sv
module stat_capture #(
    parameter int AS_W  = 4,
    parameter int SEG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [AS_W-1:0]  as_i,
    output logic [SEG_W-1:0] seg_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seg_o <= '0;
        else if (capture_i) seg_o <= as_i[SEG_W-1:0];
    end
endmodule

// File: rtl/lane_decode.sv
module lane_decode (
    input  logic valid_i,
    input  logic a0_i,
    input  logic bhe_n_i,
    output logic even_o,
    output logic odd_o
);
    always_comb begin
        even_o = valid_i && !a0_i;
        odd_o  = valid_i && !bhe_n_i;
    end
endmodule

// File: rtl/addr_demux.sv
module addr_demux
    import addr_demux_pkg::*;
#(
    parameter int AD_W  = 16,
    parameter int AS_W  = 4,
    parameter int SEG_W = 2,
    localparam int ADDR_W = AD_W + AS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AD_W-1:0]   ad_i,
    input  logic [AS_W-1:0]   as_i,
    input  logic              ale_i,
    input  logic              bhe_n_i,
    input  logic              hlda_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SEG_W-1:0]  seg_o,
    output logic              even_sel_o,
    output logic              odd_sel_o,
    output logic              addr_vld_o,
    output logic              oe_o
);
    bus_phase_t        phase;
    logic              load, capture, valid;
    logic [ADDR_W-1:0] addr_q;
    logic              bhe_n_q;
    logic [SEG_W-1:0]  seg_q;
    logic              even_w, odd_w;

    phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i),
        .phase_o(phase), .load_o(load), .capture_o(capture), .valid_o(valid)
    );

    addr_capture #(.AD_W(AD_W), .AS_W(AS_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .ad_i(ad_i), .as_i(as_i), .bhe_n_i(bhe_n_i),
        .addr_o(addr_q), .bhe_n_o(bhe_n_q)
    );

    stat_capture #(.AS_W(AS_W), .SEG_W(SEG_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .capture_i(capture),
        .as_i(as_i), .seg_o(seg_q)
    );

    lane_decode u_lane (
        .valid_i(valid), .a0_i(addr_q[0]), .bhe_n_i(bhe_n_q),
        .even_o(even_w), .odd_o(odd_w)
    );

    always_comb begin
        oe_o       = !hlda_i;
        addr_o     = hlda_i ? '0 : addr_q;
        seg_o      = hlda_i ? '0 : seg_q;
        addr_vld_o = !hlda_i && valid;
        even_sel_o = !hlda_i && even_w;
        odd_sel_o  = !hlda_i && odd_w;
    end

    logic unused_phase;
    assign unused_phase = ^phase;
endmodule

// File: rtl/addr_demux_chk.sv
module addr_demux_chk #(
    parameter int AD_W  = 16,
    parameter int AS_W  = 4,
    parameter int SEG_W = 2,
    localparam int ADDR_W = AD_W + AS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AD_W-1:0]   ad_i,
    input logic [AS_W-1:0]   as_i,
    input logic              ale_i,
    input logic              hlda_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [SEG_W-1:0]  seg_o,
    input logic              even_sel_o,
    input logic              odd_sel_o,
    input logic              addr_vld_o,
    input logic              oe_o
);
    AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_i && !hlda_i) |=> (hlda_i || addr_o == $past({as_i, ad_i}))); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_i && !hlda_i) |=> (hlda_i || addr_o == $past(addr_o))); // R3
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && !ale_i) |=> (hlda_i || seg_o == $past(seg_o))); // R4
    AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ale_i |=> !addr_vld_o); // R9
    AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_vld_o) |-> (!even_sel_o && !odd_sel_o)); // R7
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_i |-> (!oe_o && addr_o == '0 && seg_o == '0 && !addr_vld_o)); // R8
endmodule

bind addr_demux addr_demux_chk #(.AD_W(AD_W), .AS_W(AS_W), .SEG_W(SEG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .as_i(as_i), .ale_i(ale_i),
    .hlda_i(hlda_i), .addr_o(addr_o), .seg_o(seg_o), .even_sel_o(even_sel_o),
    .odd_sel_o(odd_sel_o), .addr_vld_o(addr_vld_o), .oe_o(oe_o)
);

// File: tb/sim_addr_demux.sv
`timescale 1ns/1ps
module sim_addr_demux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ad_i = '0;
    logic [3:0]  as_i = '0;
    logic        ale_i = 1'b0, bhe_n_i = 1'b1, hlda_i = 1'b0;
    logic [19:0] addr_o;
    logic [1:0]  seg_o;
    logic        even_sel_o, odd_sel_o, addr_vld_o, oe_o;
    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    addr_demux u0 (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .as_i(as_i), .ale_i(ale_i),
        .bhe_n_i(bhe_n_i), .hlda_i(hlda_i), .addr_o(addr_o), .seg_o(seg_o),
        .even_sel_o(even_sel_o), .odd_sel_o(odd_sel_o),
        .addr_vld_o(addr_vld_o), .oe_o(oe_o)
    );

    // fields: ad[28:13] as[12:9] bhe_n[8] stat[7:4] seg[3:2] even[1] odd[0]
    localparam logic [28:0] VEC [6] = '{
        {16'h341B, 4'h1, 1'b0, 4'h2, 2'b10, 1'b0, 1'b1},
        {16'hCE24, 4'hB, 1'b0, 4'h3, 2'b11, 1'b1, 1'b1},
        {16'h0024, 4'hB, 1'b1, 4'h0, 2'b00, 1'b1, 1'b0},
        {16'hFFF1, 4'hF, 1'b1, 4'h5, 2'b01, 1'b0, 1'b0},
        {16'h0000, 4'h0, 1'b0, 4'hC, 2'b00, 1'b1, 1'b1},
        {16'hA5A6, 4'h7, 1'b1, 4'h9, 2'b01, 1'b1, 1'b0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 addr", addr_o, 0); chk("R1 seg", seg_o, 0);
        chk("R1 vld", addr_vld_o, 0); chk("R1 sel", {even_sel_o, odd_sel_o}, 0);
        chk("R1 oe", oe_o, 1);
        rst_n = 1'b1;
        edge_step();
        chk("R1 idle vld", addr_vld_o, 0);

        for (int i = 0; i < 6; i++) begin
            logic [28:0] v = VEC[i];
            ale_i = 1'b1; ad_i = v[28:13]; as_i = v[12:9]; bhe_n_i = v[8];
            edge_step();
            chk("R2 addr", addr_o, {v[12:9], v[28:13]});
            chk("R6 vld in latch", addr_vld_o, 0);
            ale_i = 1'b0; as_i = v[7:4]; ad_i = ~v[28:13]; bhe_n_i = ~v[8];
            edge_step();
            chk("R6 vld", addr_vld_o, 1);
            chk("R5 seg", seg_o, v[3:2]);
            chk("R7 even", even_sel_o, v[1]);
            chk("R7 odd", odd_sel_o, v[0]);
            as_i = ~v[7:4]; ad_i = 16'h5A5A;
            edge_step();
            chk("R4 seg held", seg_o, v[3:2]);
            chk("R3 addr held", addr_o, {v[12:9], v[28:13]});
        end

        // R2 tracking while strobe stays high
        ale_i = 1'b1; ad_i = 16'h1111; as_i = 4'h2; edge_step();
        ad_i = 16'h2222; as_i = 4'h3; edge_step();
        chk("R2 tracks", addr_o, 20'h32222);
        ale_i = 1'b0; as_i = 4'h1; edge_step();
        held = addr_o;
        chk("R3 close", held, 20'h32222);

        // R8 hold acknowledge
        hlda_i = 1'b1; #1;
        chk("R8 oe", oe_o, 0); chk("R8 addr", addr_o, 0);
        chk("R8 vld", addr_vld_o, 0); chk("R8 seg", seg_o, 0);
        chk("R8 sel", {even_sel_o, odd_sel_o}, 0);
        edge_step();
        hlda_i = 1'b0; #1;
        chk("R8 restore addr", addr_o, held); chk("R8 restore seg", seg_o, 2'b01);
        chk("R8 restore vld", addr_vld_o, 1); chk("R8 oe back", oe_o, 1);

        // R9 reopen drops valid
        @(negedge clk);
        ale_i = 1'b1; ad_i = 16'h0002; as_i = 4'h0; edge_step();
        chk("R9 vld drop", addr_vld_o, 0);
        chk("R7 sel off", {even_sel_o, odd_sel_o}, 0);
        ale_i = 1'b0; edge_step();
        chk("R9 vld again", addr_vld_o, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule